// File: doc/BRIEF.md
# Dual-Port Flash Read Controller with Sequential Prefetch

This block sits between a system read bus and a flash array that has two independent synchronous read ports. A control field chosen by software sets how many wait states a read takes. With zero wait states, each request drives one read port in the cycle it is presented, and the data comes back on the next cycle. The second port stays idle, which keeps power low. With one wait state, the request is registered first. In the following cycle both ports are driven: one reads the addressed word and the other reads the next sequential word. The second word is kept in a one-entry prefetch buffer. If a later request asks for exactly that word, it is answered on the next cycle without touching the array.

The address space has one bit above the main array range. That bit selects an extra user page, which lies outside the regular array and is read exactly like the main array. The page size and page count are parameters, and both must be powers of two. Requests use a valid/ready pair. In one-wait mode, ready drops for one cycle after a request that missed the prefetch buffer.

Top module: `flash_read_prefetch`

## Requirements
- R1: After reset, `cfg_ws` reads 0 (zero-wait mode), `req_ready` is 1, `rsp_valid` is 0, and neither flash port is enabled while no request is presented.
- R2: A write on `cfg_we` updates the wait-state field from the next cycle. The value 0 selects zero-wait mode. Any nonzero value is stored and read back as 1, because settings above one are not supported. Without a write, `cfg_ws` holds its value.
- R3: In zero-wait mode, a presented request is accepted at once. Port 0 is enabled in that same cycle, and `rsp_valid` rises one cycle later with the addressed word. Port 1 stays disabled for every zero-wait access.
- R4: In one-wait mode, a request that misses the prefetch buffer does not touch the array in its acceptance cycle. In the next cycle `req_ready` is 0, and both ports are enabled. Port 0 reads the addressed word and port 1 reads the next sequential word. The response arrives one cycle after that, and `req_ready` is 1 again.
- R5: In one-wait mode, a request whose normalized address equals the word fetched by port 1 for the latest miss is answered one cycle after acceptance, with that word. Neither port is enabled and `req_ready` stays 1. This also holds when the request is presented in the same cycle as the miss's response.
- R6: Any write on `cfg_we` invalidates the prefetch buffer. A following request for the prefetched address is handled as a miss.
- R7: A request address is `MAIN_AW+1` bits wide, where `MAIN_AW = log2(PAGES*WORDS)`. Bit `MAIN_AW` set selects the user page. In that case only the low `log2(WORDS)` bits index the word and the bits between are ignored. Flash port addresses are emitted in this normalized form, with the ignored bits forced to 0.
- R8: The next sequential word wraps inside its region. The last main-array word is followed by main word 0, and the last user-page word is followed by user word 0.
- R9: `rsp_valid` is high only in the cycle after an accepted zero-wait or prefetch-hit request, or in the cycle after a one-wait stall cycle. It never rises without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | WS_W | Wait-state value written |
| cfg_ws | output | WS_W | Current wait-state setting (0 or 1) |
| req_valid | input | 1 | Read request present |
| req_addr | input | MAIN_AW+1 | Read word address; top bit selects the user page |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DATA_W | Read data |
| fl_en0 | output | 1 | Flash port 0 read enable |
| fl_addr0 | output | MAIN_AW+1 | Flash port 0 normalized address |
| fl_rdata0 | input | DATA_W | Flash port 0 data, one cycle after enable |
| fl_en1 | output | 1 | Flash port 1 read enable |
| fl_addr1 | output | MAIN_AW+1 | Flash port 1 normalized address (next word) |
| fl_rdata1 | input | DATA_W | Flash port 1 data, one cycle after enable |

## Verification
Each result has its own due cycle after acceptance:
- A zero-wait read or a prefetch hit is due one cycle after acceptance.
- A one-wait miss shows its stall and both port enables one cycle after acceptance, and its data one cycle after that.
- A control write shows up on `cfg_ws` one cycle after the strobe.

The bench drives inputs on the falling edge and samples one nanosecond later. It checks the port enables in the acceptance cycle itself and then steps one falling edge at a time. It decides at the moment of issue whether to expect the stall cycle, using its own model of the prefetched address. A back-to-back request in the response cycle of a miss covers the case where the buffer is being filled in the same cycle as the hit.

// File: rtl/frp_pkg.sv
`timescale 1ns/1ps
package frp_pkg;

    typedef enum logic {
        WS_ZERO = 1'b0,
        WS_ONE  = 1'b1
    } ws_mode_e;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ISSUE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic from_pf;
    } rsp_tag_t;

    // Clear the bits that the user page ignores; keep the region bit.
    function automatic logic [31:0] frp_norm(input logic [31:0] a, input int main_aw, input int page_aw);
        logic [31:0] region = 32'd1 << main_aw;
        if ((a & region) != 32'd0)
            return (a & ((32'd1 << page_aw) - 32'd1)) | region;
        return a & (region - 32'd1);
    endfunction

    // Following word, wrapping inside the main array or the user page.
    function automatic logic [31:0] frp_next(input logic [31:0] a, input int main_aw, input int page_aw);
        logic [31:0] region = 32'd1 << main_aw;
        logic [31:0] n = frp_norm(a, main_aw, page_aw);
        if ((n & region) != 32'd0)
            return ((n + 32'd1) & ((32'd1 << page_aw) - 32'd1)) | region;
        return (n + 32'd1) & (region - 32'd1);
    endfunction

endpackage

// File: rtl/frp_cfg_reg.sv
`timescale 1ns/1ps
module frp_cfg_reg import frp_pkg::*; #(
    parameter int WS_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [WS_W-1:0] wdata,
    output ws_mode_e        mode,
    output logic [WS_W-1:0] ws_field
);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= WS_ZERO;
        else if (we)
            mode <= (wdata != '0) ? WS_ONE : WS_ZERO;
    end

    assign ws_field = WS_W'(mode);

endmodule

// File: rtl/frp_prefetch.sv
`timescale 1ns/1ps
module frp_prefetch #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic          cap,
    input  logic [DW-1:0] cap_data,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic [DW-1:0] pf_data
);

    logic          pf_valid;
    logic [AW-1:0] pf_addr;
    logic          pend_valid;
    logic [AW-1:0] pend_addr;

    // While a fill is landing, only the incoming word may be matched.
    assign hit = cap ? (pend_valid && look_addr == pend_addr)
                     : (pf_valid && look_addr == pf_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid   <= 1'b0;
            pend_valid <= 1'b0;
            pf_addr    <= '0;
            pend_addr  <= '0;
            pf_data    <= '0;
        end else begin
            if (arm) begin
                pend_valid <= 1'b1;
                pend_addr  <= arm_addr;
            end else if (cap) begin
                pend_valid <= 1'b0;
            end
            if (cap) begin
                pf_data  <= cap_data;
                pf_addr  <= pend_addr;
                pf_valid <= pend_valid;
            end
            if (flush) begin
                pf_valid   <= 1'b0;
                pend_valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/frp_seq.sv
`timescale 1ns/1ps
module frp_seq import frp_pkg::*; #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  ws_mode_e      mode,
    input  logic          hit,
    input  logic [AW-1:0] addr_n,
    output logic          ready,
    output logic          issue,
    output logic          cap,
    output logic [AW-1:0] lat_addr,
    output rsp_tag_t      tag
);

    seq_state_e state;
    logic accept, take_hit, take_miss, take_zero;

    assign ready     = (state == SEQ_IDLE);
    assign issue     = (state == SEQ_ISSUE);
    assign accept    = req_valid && ready;
    assign take_zero = accept && mode == WS_ZERO;
    assign take_hit  = accept && mode == WS_ONE && hit;
    assign take_miss = accept && mode == WS_ONE && !hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_IDLE;
            lat_addr <= '0;
            tag      <= '0;
            cap      <= 1'b0;
        end else begin
            state <= take_miss ? SEQ_ISSUE : SEQ_IDLE;
            if (take_miss)
                lat_addr <= addr_n;
            tag.valid   <= take_zero || take_hit || issue;
            tag.from_pf <= take_hit;
            cap         <= issue;
        end
    end

endmodule

// File: rtl/flash_read_prefetch.sv
`timescale 1ns/1ps
module flash_read_prefetch import frp_pkg::*; #(
    parameter int PAGES  = 16,
    parameter int WORDS  = 32,
    parameter int DATA_W = 32,
    parameter int WS_W   = 2,
    localparam int MAIN_AW = $clog2(PAGES * WORDS),
    localparam int PAGE_AW = $clog2(WORDS),
    localparam int REQ_AW  = MAIN_AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WS_W-1:0]   cfg_wdata,
    output logic [WS_W-1:0]   cfg_ws,
    input  logic              req_valid,
    input  logic [REQ_AW-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_en0,
    output logic [REQ_AW-1:0] fl_addr0,
    input  logic [DATA_W-1:0] fl_rdata0,
    output logic              fl_en1,
    output logic [REQ_AW-1:0] fl_addr1,
    input  logic [DATA_W-1:0] fl_rdata1
);

    ws_mode_e          mode;
    logic [REQ_AW-1:0] addr_n, lat_addr, lat_next;
    logic              hit, issue, cap;
    logic [DATA_W-1:0] pf_data;
    rsp_tag_t          tag;

    assign addr_n   = REQ_AW'(frp_norm(32'(req_addr), MAIN_AW, PAGE_AW));
    assign lat_next = REQ_AW'(frp_next(32'(lat_addr), MAIN_AW, PAGE_AW));

    frp_cfg_reg #(.WS_W(WS_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .mode(mode), .ws_field(cfg_ws)
    );

    frp_seq #(.AW(REQ_AW)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode),
        .hit(hit), .addr_n(addr_n), .ready(req_ready), .issue(issue),
        .cap(cap), .lat_addr(lat_addr), .tag(tag)
    );

    frp_prefetch #(.AW(REQ_AW), .DW(DATA_W)) u_pf (
        .clk(clk), .rst(rst), .flush(cfg_we), .arm(issue),
        .arm_addr(lat_next), .cap(cap), .cap_data(fl_rdata1),
        .look_addr(addr_n), .hit(hit), .pf_data(pf_data)
    );

    // Port 0: same-cycle in zero-wait mode, stall cycle in one-wait mode.
    assign fl_en0   = issue || (req_ready && req_valid && mode == WS_ZERO);
    assign fl_addr0 = issue ? lat_addr : addr_n;
    // Port 1: only ever used for the sequential prefetch.
    assign fl_en1   = issue;
    assign fl_addr1 = issue ? lat_next : '0;

    assign rsp_valid = tag.valid;
    assign rsp_data  = tag.from_pf ? pf_data : fl_rdata0;

endmodule

// File: rtl/flash_read_prefetch_chk.sv
`timescale 1ns/1ps
module flash_read_prefetch_chk import frp_pkg::*; #(
    parameter int PAGES  = 16,
    parameter int WORDS  = 32,
    parameter int DATA_W = 32,
    parameter int WS_W   = 2,
    localparam int MAIN_AW = $clog2(PAGES * WORDS),
    localparam int PAGE_AW = $clog2(WORDS),
    localparam int REQ_AW  = MAIN_AW + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [WS_W-1:0]   cfg_wdata,
    input logic [WS_W-1:0]   cfg_ws,
    input logic              req_valid,
    input logic [REQ_AW-1:0] req_addr,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              fl_en0,
    input logic [REQ_AW-1:0] fl_addr0,
    input logic              fl_en1,
    input logic [REQ_AW-1:0] fl_addr1
);

    assert_ws_saturate_R2: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> cfg_ws == (($past(cfg_wdata) != '0) ? WS_W'(1) : WS_W'(0)));

    assert_ws_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_we) |-> $stable(cfg_ws));

    assert_zero_port1_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_ws == '0 && $past(cfg_ws) == '0) |-> !fl_en1);

    assert_zero_port0_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && cfg_ws == '0) |->
        (fl_en0 && fl_addr0 == REQ_AW'(frp_norm(32'(req_addr), MAIN_AW, PAGE_AW))));

    assert_stall_both_ports_R4: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> (fl_en0 && fl_en1 &&
        fl_addr1 == REQ_AW'(frp_next(32'(fl_addr0), MAIN_AW, PAGE_AW))));

    assert_stall_single_R4: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    assert_stall_then_rsp_R4: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> rsp_valid);

    assert_one_wait_accept_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && cfg_ws == WS_W'(1)) |-> (!fl_en0 && !fl_en1));

    assert_rsp_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(!req_ready)));

endmodule

bind flash_read_prefetch flash_read_prefetch_chk #(
    .PAGES(PAGES), .WORDS(WORDS), .DATA_W(DATA_W), .WS_W(WS_W)
) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_ws(cfg_ws), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .fl_en0(fl_en0),
    .fl_addr0(fl_addr0), .fl_en1(fl_en1), .fl_addr1(fl_addr1)
);

// File: tb/flash_read_prefetch_test.sv
`timescale 1ns/1ps
module flash_read_prefetch_test;

    localparam int PAGES = 16;
    localparam int WORDS = 32;
    localparam int DW    = 32;
    localparam int WSW   = 2;
    localparam int MAW   = 9;
    localparam int PAW   = 5;
    localparam int AW    = MAW + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [WSW-1:0] cfg_wdata = '0;
    logic [WSW-1:0] cfg_ws;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          fl_en0, fl_en1;
    logic [AW-1:0] fl_addr0, fl_addr1;
    logic [DW-1:0] fl_rdata0 = '0, fl_rdata1 = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit            m_mode = 1'b0;
    bit            pf_ok = 1'b0;
    logic [AW-1:0] pf_addr_m = '0;

    always #2.5 clk = ~clk;

    flash_read_prefetch #(.PAGES(PAGES), .WORDS(WORDS), .DATA_W(DW), .WS_W(WSW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_ws(cfg_ws),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fl_en0(fl_en0), .fl_addr0(fl_addr0), .fl_rdata0(fl_rdata0),
        .fl_en1(fl_en1), .fl_addr1(fl_addr1), .fl_rdata1(fl_rdata1)
    );

    function automatic logic [AW-1:0] m_norm(input logic [AW-1:0] a);
        if (a[AW-1]) return {1'b1, {(MAW-PAW){1'b0}}, a[PAW-1:0]};
        return {1'b0, a[MAW-1:0]};
    endfunction

    function automatic logic [AW-1:0] m_next(input logic [AW-1:0] a);
        logic [AW-1:0] n = m_norm(a);
        if (n[AW-1]) return {1'b1, {(MAW-PAW){1'b0}}, PAW'(n[PAW-1:0] + 1'b1)};
        return {1'b0, MAW'(n[MAW-1:0] + 1'b1)};
    endfunction

    function automatic logic [DW-1:0] m_word(input logic [AW-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0000 ^ (32'(a) << 20);
    endfunction

    // Synchronous two-port flash model: data one cycle after enable.
    always @(posedge clk) begin
        if (fl_en0) fl_rdata0 <= m_word(fl_addr0);
        if (fl_en1) fl_rdata1 <= m_word(fl_addr1);
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [WSW-1:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0; #1;
        chk(cfg_ws == ((v != 0) ? WSW'(1) : WSW'(0)), "R2 ws readback", 64'(cfg_ws), 64'(v != 0));
        m_mode = (v != 0);
        pf_ok = 1'b0;   // R6
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        logic [AW-1:0] n = m_norm(a);
        bit hit = m_mode && pf_ok && n == pf_addr_m;
        string tag = !m_mode ? "R3" : (hit ? "R5" : "R4");
        @(negedge clk); req_valid = 1'b1; req_addr = a; #1;
        chk(req_ready, {tag, " ready at accept"}, 64'(req_ready), 1);
        if (!m_mode) begin
            chk(fl_en0 && !fl_en1, "R3 only port0", {fl_en0, fl_en1}, 2'b10);
            chk(fl_addr0 == n, "R7 port0 address", 64'(fl_addr0), 64'(n));
        end else begin
            chk(!fl_en0 && !fl_en1, {tag, " no port at accept"}, {fl_en0, fl_en1}, 2'b00);
        end
        @(negedge clk); req_valid = 1'b0; #1;
        if (m_mode && !hit) begin
            chk(!req_ready && fl_en0 && fl_en1 && !rsp_valid, "R4 stall cycle",
                {req_ready, fl_en0, fl_en1, rsp_valid}, 4'b0110);
            chk(fl_addr0 == n, "R7 stall port0 address", 64'(fl_addr0), 64'(n));
            chk(fl_addr1 == m_next(n), "R8 next address", 64'(fl_addr1), 64'(m_next(n)));
            @(negedge clk); #1;
            pf_addr_m = m_next(n);
            pf_ok = 1'b1;
        end
        chk(rsp_valid && req_ready, {tag, " response valid"}, {rsp_valid, req_ready}, 2'b11);
        chk(rsp_data == m_word(n), {tag, " response data"}, 64'(rsp_data), 64'(m_word(n)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] b;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        // R1 reset state
        chk(cfg_ws == '0 && req_ready && !rsp_valid && !fl_en0 && !fl_en1, "R1 reset state",
            {cfg_ws, req_ready, rsp_valid, fl_en0, fl_en1}, {2'b00, 3'b100, 2'b00});

        // R2 saturation of wait-state field
        write_cfg(2'd2);
        write_cfg(2'd3);
        write_cfg(2'd0);

        // R3 / R7 zero-wait reads, main array and user page with ignored bits
        do_read(10'h005);
        do_read(10'h1FF);
        do_read(10'h3E7);
        // R9 idle: no response without a request
        repeat (3) begin
            @(negedge clk); #1;
            chk(!rsp_valid && !fl_en0 && !fl_en1, "R9 idle quiet", {rsp_valid, fl_en0, fl_en1}, 3'b000);
        end

        // R4 / R5 one-wait miss then sequential hit
        write_cfg(2'd1);
        do_read(10'h040);
        do_read(10'h041);
        do_read(10'h042);
        // R8 wrap: main last word, user last word (with ignored bits)
        do_read(10'h1FF);
        do_read(10'h000);
        do_read(10'h3FF);
        do_read(10'h200);

        // R6 control write invalidates prefetch
        do_read(10'h080);
        write_cfg(2'd1);
        do_read(10'h081);

        // R5 back-to-back: hit presented in the miss's response cycle
        b = 10'h123;
        @(negedge clk); req_valid = 1'b1; req_addr = b;
        @(negedge clk); req_valid = 1'b0; #1;
        chk(!req_ready, "R4 stall before chained hit", 64'(req_ready), 0);
        @(negedge clk); req_valid = 1'b1; req_addr = m_next(b); #1;
        chk(rsp_valid && rsp_data == m_word(b), "R4 miss data chained", 64'(rsp_data), 64'(m_word(b)));
        chk(req_ready && !fl_en0 && !fl_en1, "R5 chained accept quiet", {req_ready, fl_en0, fl_en1}, 3'b100);
        @(negedge clk); req_valid = 1'b0; #1;
        chk(rsp_valid && req_ready && rsp_data == m_word(m_next(b)), "R5 chained hit data",
            64'(rsp_data), 64'(m_word(m_next(b))));
        pf_addr_m = m_next(b);
        pf_ok = 1'b1;

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom % 10);
            if (r == 0)
                write_cfg(WSW'($urandom % 4));
            else if (r < 5 && pf_ok)
                do_read(pf_addr_m);
            else
                do_read(AW'($urandom));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule